// File: doc/BRIEF.md
# Peripheral Bus Master Sequencer

This block converts single-word read and write requests from a host into strobe-level transactions on a 16-bit peripheral bus. The bus has an active-low chip select, separate active-low read and write strobes, a 6-bit word address and an active-low ready input that the peripheral uses to stretch the strobe. The host presents a byte address, and the block turns it into a word index from byte-address bits [7:2]. For example, host address 0xFF0B0 selects bus word 0x2C.

A transaction moves through four phases, each lasting at least one clock. First comes address setup, where chip select falls and the address is driven, together with the write data on a write. Next is the strobe phase, where the strobe is held low until ready is sampled low. Then comes strobe release, where the strobe is high and chip select is still low. Last is the return to idle, where chip select rises. The data bus is brought out as an output value, an output enable and an input value, so that the pad ring can build the tri-state driver. Read data is captured in the same cycle in which ready is sampled low. It is returned to the host together with a one-cycle completion pulse.

Top module: `pbus_master`

## Requirements
- R1: While reset is active and in the first cycle after it, bus_cs_n, bus_rd_n and bus_wr_n are 1, and bus_doe and done are 0.
- R2: bus_addr equals host address bits [ADDR_LSB+BUS_AW-1:ADDR_LSB], which are bits [7:2] by default, so 0xFF0B0 gives 0x2C. The value is latched when the request is accepted and holds steady for as long as bus_cs_n is 0.
- R3: A write drives bus_cs_n to 0 with bus_addr and bus_dout valid and bus_wr_n still 1, in the cycle after the request is sampled. bus_wr_n falls one cycle later.
- R4: During a write, bus_doe is 1 and bus_dout holds the request data from chip-select assertion until chip-select release, covering both edges of bus_wr_n. bus_doe is 0 whenever bus_cs_n is 1 and throughout every read.
- R5: Once low, a strobe stays low for as long as bus_rdy_n is sampled 1 on a rising clock edge.
- R6: A read drives bus_cs_n to 0 with bus_doe 0 and bus_rd_n 1 for one cycle, after which bus_rd_n goes to 0.
- R7: bus_din is captured on the edge where bus_rdy_n is sampled 0 during the read strobe, and it appears on rdata when done is 1.
- R8: The strobe rises in the cycle after ready is sampled 0, while bus_cs_n is still 0. bus_cs_n rises one cycle after that, in the same cycle in which done is 1 for exactly one cycle.
- R9: req is ignored while a transaction is in progress. It does not change bus_addr, and no new transaction follows if req is withdrawn before idle.
- R10: bus_rd_n and bus_wr_n are never both 0, and neither strobe is 0 while bus_cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request, sampled in idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | HOST_AW (20) | Host byte address |
| wdata | input | DATA_W (16) | Host write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W (16) | Read data, valid with done |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | BUS_AW (6) | Peripheral word address |
| bus_dout | output | DATA_W (16) | Data bus output value |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W (16) | Data bus input value |
| bus_rdy_n | input | 1 | Peripheral ready, active low |

## Verification
The bench builds the block with its default parameters: a 20-bit host address, a 6-bit bus address taken from bits [7:2], and a 16-bit data bus. With these values, a sweep over all 64 bus words is small enough to run in full. Every word is written and then read back. Each access uses a different combination of upper and lower host-address bits, data computed arithmetically from the index, and zero to three ready wait cycles. This exercises every address translation, both transfer directions and the strobe stretch. The sweep also includes the 0xFF0B0 mapping and a request raised mid-transaction.

// File: rtl/pbus_pkg.sv
// Shared definitions for the peripheral bus master sequencer.
package pbus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_STROBE  = 2'd2,
        PH_RELEASE = 2'd3
    } pbus_phase_e;
endpackage

// File: rtl/pbus_addr_map.sv
// Host byte address to peripheral word address translation.
// Assumes HOST_AW >= ADDR_LSB + BUS_AW and ADDR_LSB >= 1.
module pbus_addr_map #(
    parameter int HOST_AW  = 20,
    parameter int BUS_AW   = 6,
    parameter int ADDR_LSB = 2
) (
    input  logic [HOST_AW-1:0] host_addr,
    output logic [BUS_AW-1:0]  word_addr
);
    localparam int TOP_BIT = ADDR_LSB + BUS_AW;

    // The remaining address bits are outside the bus window; they are
    // reduced into one named signal.
    logic unused_bits;

    // Select the word-index window of the byte address.
    always_comb begin
        word_addr   = host_addr[ADDR_LSB +: BUS_AW];
        unused_bits = ^{host_addr[HOST_AW-1:TOP_BIT], host_addr[ADDR_LSB-1:0]};
    end
endmodule

// File: rtl/pbus_fsm.sv
// Phase sequencer: idle -> setup -> strobe (held while ready is high)
// -> release -> idle. It raises accept in idle when a request is present,
// capture when ready is sampled low during the strobe, and done for one
// cycle on the return to idle. Assumes bus_rdy_n is already synchronous.
module pbus_fsm
    import pbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        rdy_n,
    output pbus_phase_e phase,
    output logic        accept,
    output logic        capture,
    output logic        done
);
    pbus_phase_e phase_nx;

    // Next-phase decode and event strobes.
    always_comb begin
        accept   = (phase == PH_IDLE) && req;
        capture  = (phase == PH_STROBE) && !rdy_n;
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:    if (req) phase_nx = PH_SETUP;
            PH_SETUP:   phase_nx = PH_STROBE;
            PH_STROBE:  if (!rdy_n) phase_nx = PH_RELEASE;
            PH_RELEASE: phase_nx = PH_IDLE;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    // Phase register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase == PH_RELEASE);
        end
    end
endmodule

// File: rtl/pbus_datapath.sv
// Transaction registers: direction, word address and write data are latched
// on accept and held until the next accept, so the bus lines stay at a stable
// value in idle. Read data is latched on capture during reads.
module pbus_datapath #(
    parameter int BUS_AW = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              we_in,
    input  logic [BUS_AW-1:0] waddr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] din,
    output logic              we_q,
    output logic [BUS_AW-1:0] waddr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    // Request fields, loaded when a new transaction starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= we_in;
            waddr_q <= waddr_in;
            wdata_q <= wdata_in;
        end
    end

    // Read data register, loaded when ready ends a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (capture && !we_q)
            rdata_q <= din;
    end
endmodule

// File: rtl/pbus_master.sv
// Peripheral bus master sequencer, top level. It runs one word transfer per
// host request on a bus with chip select, read and write strobes, and an
// active-low ready. Bus controls decode from registered phase and
// transaction state. The data pad is split into dout, oe and din for the
// pad ring.
module pbus_master
    import pbus_pkg::*;
#(
    parameter int HOST_AW  = 20,
    parameter int BUS_AW   = 6,
    parameter int DATA_W   = 16,
    parameter int ADDR_LSB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [HOST_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic               bus_cs_n,
    output logic               bus_rd_n,
    output logic               bus_wr_n,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_doe,
    input  logic [DATA_W-1:0]  bus_din,
    input  logic               bus_rdy_n
);
    pbus_phase_e       phase;
    logic              accept;
    logic              capture;
    logic              we_q;
    logic [BUS_AW-1:0] word_addr;

    pbus_addr_map #(
        .HOST_AW (HOST_AW),
        .BUS_AW  (BUS_AW),
        .ADDR_LSB(ADDR_LSB)
    ) u_map (
        .host_addr(addr),
        .word_addr(word_addr)
    );

    pbus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .rdy_n  (bus_rdy_n),
        .phase  (phase),
        .accept (accept),
        .capture(capture),
        .done   (done)
    );

    pbus_datapath #(
        .BUS_AW(BUS_AW),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .capture (capture),
        .we_in   (we),
        .waddr_in(word_addr),
        .wdata_in(wdata),
        .din     (bus_din),
        .we_q    (we_q),
        .waddr_q (bus_addr),
        .wdata_q (bus_dout),
        .rdata_q (rdata)
    );

    // Bus control decode from the current phase and direction.
    always_comb begin
        bus_cs_n = (phase == PH_IDLE);
        bus_wr_n = !((phase == PH_STROBE) && we_q);
        bus_rd_n = !((phase == PH_STROBE) && !we_q);
        bus_doe  = we_q && (phase != PH_IDLE);
    end
endmodule

// File: rtl/pbus_master_chk.sv
// Protocol checker for pbus_master, attached through bind. It only observes
// the top-level ports.
module pbus_master_chk #(
    parameter int BUS_AW = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_doe,
    input logic              bus_rdy_n
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_strobe_in_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && bus_rdy_n) |=> !bus_wr_n);

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n && bus_rdy_n) |=> !bus_rd_n);

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_addr));

    assert_doe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !bus_cs_n);

    assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe)) |-> $stable(bus_dout));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cs_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_wr_n) || $rose(bus_rd_n)) |-> !bus_cs_n);
endmodule

bind pbus_master pbus_master_chk #(
    .BUS_AW(BUS_AW),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_doe  (bus_doe),
    .bus_rdy_n(bus_rdy_n)
);

// File: tb/test_pbus_master.sv
`timescale 1ns/1ps
// Sweep bench: writes then reads every bus word, with varied host address
// bits, data and ready wait counts.
module test_pbus_master;
    localparam int HOST_AW = 20;
    localparam int BUS_AW  = 6;
    localparam int DATA_W  = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req = 1'b0;
    logic               we = 1'b0;
    logic [HOST_AW-1:0] addr = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic               done;
    logic [DATA_W-1:0]  rdata;
    logic               bus_cs_n, bus_rd_n, bus_wr_n, bus_doe;
    logic [BUS_AW-1:0]  bus_addr;
    logic [DATA_W-1:0]  bus_dout;
    logic [DATA_W-1:0]  bus_din = '0;
    logic               bus_rdy_n = 1'b1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pbus_master i_pbus_master (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .done(done), .rdata(rdata), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_rdy_n(bus_rdy_n)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int i);
        return DATA_W'((i * 16'h0405) ^ 16'hA5C3);
    endfunction

    // One transfer. The expected word address is worked out from the host address.
    // If poke is set, a second request is raised during the strobe (R9).
    task automatic xfer(input bit w, input logic [HOST_AW-1:0] ha,
                        input logic [DATA_W-1:0] d, input int waits, input bit poke);
        logic [BUS_AW-1:0] ea;
        ea = BUS_AW'(ha >> 2);
        req = 1'b1; we = w; addr = ha; wdata = d; bus_rdy_n = 1'b1;
        bus_din = w ? ~d : d;
        @(negedge clk);
        req = 1'b0;
        check(!bus_cs_n && bus_wr_n && bus_rd_n, w ? "R3 setup" : "R6 setup",
              {bus_cs_n, bus_wr_n, bus_rd_n}, 3'b011);
        check(bus_addr == ea, "R2 addr", bus_addr, ea);
        if (w) check(bus_doe && bus_dout == d, "R3 wdata", {bus_doe, bus_dout}, {1'b1, d});
        else   check(!bus_doe, "R6 doe low", bus_doe, 0);
        @(negedge clk);
        if (w) check(!bus_wr_n && bus_rd_n, "R3 wr low", {bus_wr_n, bus_rd_n}, 2'b01);
        else   check(!bus_rd_n && bus_wr_n, "R6 rd low", {bus_rd_n, bus_wr_n}, 2'b01);
        if (poke) begin
            req = 1'b1; we = ~w; addr = ~ha;
        end
        for (int k = 0; k < waits; k++) begin
            @(negedge clk);
            req = 1'b0;
            check(w ? !bus_wr_n : !bus_rd_n, "R5 held", {bus_wr_n, bus_rd_n}, 0);
            check(bus_addr == ea, "R9 addr held", bus_addr, ea);
        end
        bus_rdy_n = 1'b0;
        @(negedge clk);
        req = 1'b0;
        bus_rdy_n = 1'b1;
        bus_din = 16'hDEAD;
        check(bus_wr_n && bus_rd_n && !bus_cs_n && !done, "R8 release",
              {bus_wr_n, bus_rd_n, bus_cs_n, done}, 4'b1100);
        if (w) check(bus_doe && bus_dout == d, "R4 wdata held", {bus_doe, bus_dout}, {1'b1, d});
        check(bus_addr == ea, "R2 addr held", bus_addr, ea);
        @(negedge clk);
        check(bus_cs_n && done, "R8 cs off with done", {bus_cs_n, done}, 2'b11);
        check(!bus_doe, "R4 doe off", bus_doe, 0);
        if (!w) check(rdata == d, "R7 rdata", rdata, d);
        @(negedge clk);
        check(!done && bus_cs_n, "R8 done one cycle", {done, bus_cs_n}, 2'b01);
        if (poke) begin
            @(negedge clk);
            check(bus_cs_n && bus_addr == ea, "R9 no new transfer", {bus_cs_n, bus_addr}, {1'b1, ea});
        end
    endtask

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe && !done, "R1 in reset",
              {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, done}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe && !done, "R1 after reset",
              {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, done}, 5'b11100);
        // Mapping example: 0xFF0B0 selects word 0x2C.
        xfer(1'b1, 20'hFF0B0, 16'hBBAA, 0, 1'b0);
        xfer(1'b0, 20'hFF0B0, 16'h1234, 2, 1'b0);
        // Full sweep of the word space in both directions.
        for (int i = 0; i < 64; i++) begin
            logic [HOST_AW-1:0] ha;
            ha = HOST_AW'(((i * 37 + 5) << 8) | (i << 2) | (i & 3));
            xfer(1'b1, ha, pat(i), i % 4, 1'b0);
            xfer(1'b0, ha ^ 20'h3, pat(i) ^ 16'h5A5A, (i + 1) % 4, 1'b0);
        end
        // Request raised mid-transaction is ignored.
        xfer(1'b1, 20'h00104, 16'hC0DE, 2, 1'b1);
        xfer(1'b0, 20'h001FC, 16'hFACE, 3, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule